// File: doc/BRIEF.md
# Padding-Aware Block Cipher DMA Engine

This engine moves a message from a source buffer through an external 64-bit block cipher and into a destination buffer, so that a processor only has to program one job. It fetches 32-bit words over a simple memory bus. Every access is stretched by a programmable number of wait cycles. A run of header words at the start of the buffer is passed straight through to the destination without touching the cipher. The payload is then gathered into 64-bit blocks, each block is handed to the cipher over a valid/ready stream, and the cipher's answer is written back as two words.

In encrypt mode the engine pads the message to a whole number of blocks. It appends N bytes of value N, with N from 1 to 8, so an exact multiple of eight bytes gains a full block of padding. In decrypt mode it inspects the last block the cipher returns, removes valid padding from the reported length, and flags malformed padding. A per-job byte-order select chooses how the bytes of each bus word map onto the block. At the end of a job a sticky done flag is raised and the resulting output length is reported.

Top module: `padding_dma_engine`

## Requirements
- R1: After reset, busy, doneIrq, padError, busReq and cipherInValid are all 0.
- R2: The first hdrWords words at srcAddr are copied unchanged, word for word, to dstAddr onward, and are not sent to the cipher.
- R3: With littleEndian=0, bits 31:24 of a bus word hold its lowest-addressed byte. The first payload byte becomes bits 63:56 of a block and the eighth becomes bits 7:0. Each cipher result is written to consecutive words right after the header, in the same byte mapping.
- R4: With littleEndian=1, the byte order inside each 32-bit word is reversed, both when forming blocks and when writing results: bits 7:0 of a word hold its lowest-addressed byte.
- R5: In encrypt mode (decrypt=0), let r be the number of payload bytes left for the final block, 0..7. Its bytes r..7 are replaced by the value 8-r before going to the cipher. A payload of length 0 or any multiple of 8 therefore ends with an extra block of eight 0x08 bytes.
- R6: In decrypt mode the payload length is a multiple of 8. Let N be bits 7:0 of the last cipher result. If N is 1..8 and the last N bytes all equal N, outCount excludes those N bytes and padError stays 0.
- R7: If the last decrypted block has N=0, N>8, or any of its last N bytes differs from N, padError is set. outCount then counts the whole block. The final block is always written to the destination in full.
- R8: Each bus access keeps busReq high with busAddr and busWe stable for exactly waitStates+1 cycles. Read data is taken and write data is committed only in the last of those cycles.
- R9: Once cipherInValid is raised, it stays high with cipherInData unchanged until cipherInReady is seen.
- R10: When a job ends, doneIrq rises and busy falls. doneIrq stays high until the next accepted start. outCount then equals 4*hdrWords plus the payload output bytes.
- R11: A start pulse while busy is ignored, and the running job completes with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job with the current settings (honoured only when idle) |
| decrypt | input | 1 | 1 = decrypt and strip padding, 0 = encrypt and add padding |
| littleEndian | input | 1 | Byte order select for payload words |
| waitStates | input | WAIT_W | Extra cycles per bus access |
| hdrWords | input | HDR_W | Number of header words passed through |
| payloadLen | input | LEN_W | Payload length in bytes after the header |
| srcAddr | input | ADDR_W | Byte address of the source buffer (word aligned) |
| dstAddr | input | ADDR_W | Byte address of the destination buffer (word aligned) |
| busReq | output | 1 | Bus access in progress |
| busWe | output | 1 | Access is a write |
| busAddr | output | ADDR_W | Byte address of the access |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, valid in the last access cycle |
| cipherInValid | output | 1 | Block offered to the cipher |
| cipherInReady | input | 1 | Cipher accepts the block |
| cipherInData | output | 64 | Block to the cipher |
| cipherOutValid | input | 1 | Cipher result available |
| cipherOutReady | output | 1 | Engine accepts the result |
| cipherOutData | input | 64 | Cipher result |
| busy | output | 1 | A job is running |
| doneIrq | output | 1 | Sticky end-of-job flag |
| padError | output | 1 | Malformed padding seen in the last decrypt job |
| outCount | output | CNT_W | Output byte count of the last job |

## Verification
The inline properties check on every cycle that bus accesses and offered cipher blocks hold still until they finish. They also check that a pad error can only appear in decrypt mode, that the done flag only follows a busy period and excludes activity, and that a start during a job does not reload its settings. Whether the right bytes land in the right place cannot be seen by a property. The byte orders, the header pass-through, the pad value chosen for each remainder, the good and malformed trailer cases and the reported counts are therefore shown by bench scenarios against a byte-level model. Exact wait-state timing is shown by a bus stub that only presents true read data in the last cycle of an access.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_W     = 64;
  localparam int BLK_BYTES = BLK_W / 8;
  localparam int KEEP_W    = $clog2(BLK_BYTES);
  localparam int PADN_W    = KEEP_W + 1;

  typedef enum logic [1:0] {
    WSEL_HDR = 2'd0,
    WSEL_HI  = 2'd1,
    WSEL_LO  = 2'd2
  } wrSel_e;

  typedef struct packed {
    logic              load;
    logic              capW0;
    logic              capW1;
    logic              clrWords;
    logic              capRes;
    logic              padFinal;
    logic [KEEP_W-1:0] padKeep;
    wrSel_e            wrSel;
  } ctrlStb_t;
endpackage

// File: rtl/cdma_dpath.sv
module cdma_dpath
  import cdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              littleEndian,
  input  logic [WORD_W-1:0] busRdata,
  output logic [WORD_W-1:0] busWdata,
  output logic [BLK_W-1:0]  cipherInData,
  input  logic [BLK_W-1:0]  cipherOutData,
  output logic              padOk,
  output logic [PADN_W-1:0] padN
);
  logic              leQ;
  logic [WORD_W-1:0] w0Q, w1Q;
  logic [BLK_W-1:0]  resQ;
  logic [BLK_W-1:0]  blkRaw;
  logic [7:0]        padByte;
  logic [7:0]        padCode;
  logic [BLK_BYTES-1:0] padMatch;

  function automatic logic [WORD_W-1:0] orderWord(input logic [WORD_W-1:0] w, input logic le);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_W / 8; b++) begin
      r[8*b +: 8] = le ? w[WORD_W-8-8*b +: 8] : w[8*b +: 8];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leQ  <= 1'b0;
      w0Q  <= '0;
      w1Q  <= '0;
      resQ <= '0;
    end else begin
      if (stb.load)     leQ <= littleEndian;
      if (stb.clrWords) begin
        w0Q <= '0;
        w1Q <= '0;
      end
      if (stb.capW0)    w0Q  <= busRdata;
      if (stb.capW1)    w1Q  <= busRdata;
      if (stb.capRes)   resQ <= cipherOutData;
    end
  end

  assign blkRaw  = {orderWord(w0Q, leQ), orderWord(w1Q, leQ)};
  assign padByte = 8'(BLK_BYTES) - 8'(stb.padKeep);
  assign padCode = resQ[7:0];

  for (genvar i = 0; i < BLK_BYTES; i++) begin : g_lane
    localparam int HI = BLK_W - 1 - 8 * i;
    assign cipherInData[HI -: 8] =
      (stb.padFinal && (KEEP_W'(i) >= stb.padKeep)) ? padByte : blkRaw[HI -: 8];
    assign padMatch[i] =
      ((9'(i) + {1'b0, padCode}) < 9'(BLK_BYTES)) || (resQ[HI -: 8] == padCode);
  end

  assign padOk = (padCode != 8'd0) && (padCode <= 8'(BLK_BYTES)) && (&padMatch);
  assign padN  = padCode[PADN_W-1:0];

  always_comb begin
    unique case (stb.wrSel)
      WSEL_HDR: busWdata = w0Q;
      WSEL_HI:  busWdata = orderWord(resQ[BLK_W-1 -: WORD_W], leQ);
      default:  busWdata = orderWord(resQ[WORD_W-1:0], leQ);
    endcase
  end
endmodule

// File: rtl/cdma_ctrl.sv
module cdma_ctrl
  import cdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int HDR_W  = 8,
  parameter int WAIT_W = 4,
  parameter int CNT_W  = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              decrypt,
  input  logic [WAIT_W-1:0] waitStates,
  input  logic [HDR_W-1:0]  hdrWords,
  input  logic [LEN_W-1:0]  payloadLen,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic              cipherInValid,
  input  logic              cipherInReady,
  input  logic              cipherOutValid,
  output logic              cipherOutReady,
  input  logic              padOk,
  input  logic [PADN_W-1:0] padN,
  output ctrlStb_t          stb,
  output logic              busy,
  output logic              doneIrq,
  output logic              padError,
  output logic [CNT_W-1:0]  outCount
);
  typedef enum logic [3:0] {
    S_IDLE, S_HRD, S_HWR, S_NEXT, S_RD0, S_RD1, S_SEND, S_RECV, S_WR0, S_WR1
  } state_e;

  localparam int BB_W = PADN_W;

  state_e             state;
  logic [ADDR_W-1:0]  srcPtr, dstPtr;
  logic [HDR_W-1:0]   hdrLeft;
  logic [LEN_W-1:0]   remLen;
  logic [WAIT_W-1:0]  waitCfg, waitCnt;
  logic [BB_W-1:0]    blkBytes;
  logic               decMode, finalBlk, finalDone, doneQ, padErrQ;
  logic [CNT_W-1:0]   outCnt;
  logic               accessing, accDone, writing, jobEnd, remBig;

  assign writing   = (state == S_HWR) || (state == S_WR0) || (state == S_WR1);
  assign accessing = writing || (state == S_HRD) || (state == S_RD0) || (state == S_RD1);
  assign accDone   = accessing && (waitCnt == waitCfg);
  assign busReq    = accessing;
  assign busWe     = writing;
  assign busAddr   = writing ? dstPtr : srcPtr;
  assign cipherInValid  = (state == S_SEND);
  assign cipherOutReady = (state == S_RECV);
  assign busy      = (state != S_IDLE);
  assign doneIrq   = doneQ;
  assign padError  = padErrQ;
  assign outCount  = outCnt;
  assign jobEnd    = finalDone || (decMode && (remLen == '0));
  assign remBig    = (remLen >= LEN_W'(BLK_BYTES));

  always_comb begin
    stb          = '0;
    stb.load     = (state == S_IDLE) && start;
    stb.capW0    = accDone && ((state == S_HRD) || (state == S_RD0));
    stb.capW1    = accDone && (state == S_RD1);
    stb.clrWords = (state == S_NEXT);
    stb.capRes   = (state == S_RECV) && cipherOutValid;
    stb.padFinal = !decMode && finalBlk;
    stb.padKeep  = blkBytes[KEEP_W-1:0];
    stb.wrSel    = (state == S_HWR) ? WSEL_HDR : ((state == S_WR0) ? WSEL_HI : WSEL_LO);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !accessing || accDone) waitCnt <= '0;
    else                                waitCnt <= waitCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      srcPtr    <= '0;
      dstPtr    <= '0;
      hdrLeft   <= '0;
      remLen    <= '0;
      waitCfg   <= '0;
      blkBytes  <= '0;
      decMode   <= 1'b0;
      finalBlk  <= 1'b0;
      finalDone <= 1'b0;
      doneQ     <= 1'b0;
      padErrQ   <= 1'b0;
      outCnt    <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          srcPtr    <= srcAddr;
          dstPtr    <= dstAddr;
          hdrLeft   <= hdrWords;
          remLen    <= payloadLen;
          waitCfg   <= waitStates;
          decMode   <= decrypt;
          finalBlk  <= 1'b0;
          finalDone <= 1'b0;
          doneQ     <= 1'b0;
          padErrQ   <= 1'b0;
          outCnt    <= '0;
          state     <= (hdrWords != '0) ? S_HRD : S_NEXT;
        end
        S_HRD: if (accDone) begin
          srcPtr <= srcPtr + ADDR_W'(4);
          state  <= S_HWR;
        end
        S_HWR: if (accDone) begin
          dstPtr  <= dstPtr + ADDR_W'(4);
          hdrLeft <= hdrLeft - 1'b1;
          outCnt  <= outCnt + CNT_W'(4);
          state   <= (hdrLeft == HDR_W'(1)) ? S_NEXT : S_HRD;
        end
        S_NEXT: begin
          if (jobEnd) begin
            doneQ <= 1'b1;
            state <= S_IDLE;
          end else begin
            finalBlk <= decMode ? (remLen <= LEN_W'(BLK_BYTES)) : !remBig;
            blkBytes <= remBig ? BB_W'(BLK_BYTES) : BB_W'(remLen);
            remLen   <= remBig ? remLen - LEN_W'(BLK_BYTES) : '0;
            state    <= (remLen != '0) ? S_RD0 : S_SEND;
          end
        end
        S_RD0: if (accDone) begin
          srcPtr <= srcPtr + ADDR_W'(4);
          state  <= (blkBytes > BB_W'(4)) ? S_RD1 : S_SEND;
        end
        S_RD1: if (accDone) begin
          srcPtr <= srcPtr + ADDR_W'(4);
          state  <= S_SEND;
        end
        S_SEND: if (cipherInReady) state <= S_RECV;
        S_RECV: if (cipherOutValid) state <= S_WR0;
        S_WR0: if (accDone) begin
          dstPtr <= dstPtr + ADDR_W'(4);
          state  <= S_WR1;
        end
        S_WR1: if (accDone) begin
          dstPtr <= dstPtr + ADDR_W'(4);
          if (decMode && finalBlk) begin
            padErrQ <= !padOk;
            outCnt  <= outCnt + (padOk ? CNT_W'(BLK_BYTES) - CNT_W'(padN) : CNT_W'(BLK_BYTES));
          end else begin
            outCnt <= outCnt + CNT_W'(BLK_BYTES);
          end
          if (finalBlk) finalDone <= 1'b1;
          state <= S_NEXT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  access_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !accDone |=> busReq && $stable(busAddr) && $stable(busWe));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> !busy && !busReq && !cipherInValid);

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneIrq) |-> $past(busy));

  // R7
  pad_err_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    padError |-> decMode);

  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> $stable(decMode) && $stable(waitCfg));
endmodule

// File: rtl/padding_dma_engine.sv
module padding_dma_engine
  import cdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int HDR_W  = 8,
  parameter int WAIT_W = 4,
  localparam int CNT_W = ((LEN_W > HDR_W + 2) ? LEN_W : HDR_W + 2) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              decrypt,
  input  logic              littleEndian,
  input  logic [WAIT_W-1:0] waitStates,
  input  logic [HDR_W-1:0]  hdrWords,
  input  logic [LEN_W-1:0]  payloadLen,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  input  logic [31:0]       busRdata,
  output logic              cipherInValid,
  input  logic              cipherInReady,
  output logic [63:0]       cipherInData,
  input  logic              cipherOutValid,
  output logic              cipherOutReady,
  input  logic [63:0]       cipherOutData,
  output logic              busy,
  output logic              doneIrq,
  output logic              padError,
  output logic [CNT_W-1:0]  outCount
);
  ctrlStb_t          stb;
  logic              padOk;
  logic [PADN_W-1:0] padN;

  cdma_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .HDR_W(HDR_W), .WAIT_W(WAIT_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt),
    .waitStates(waitStates), .hdrWords(hdrWords), .payloadLen(payloadLen),
    .srcAddr(srcAddr), .dstAddr(dstAddr),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .cipherInValid(cipherInValid), .cipherInReady(cipherInReady),
    .cipherOutValid(cipherOutValid), .cipherOutReady(cipherOutReady),
    .padOk(padOk), .padN(padN), .stb(stb),
    .busy(busy), .doneIrq(doneIrq), .padError(padError), .outCount(outCount)
  );

  cdma_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .littleEndian(littleEndian),
    .busRdata(busRdata), .busWdata(busWdata),
    .cipherInData(cipherInData), .cipherOutData(cipherOutData),
    .padOk(padOk), .padN(padN)
  );

  // R9
  cipher_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cipherInValid && !cipherInReady |=> cipherInValid && $stable(cipherInData));
endmodule

// File: tb/padding_dma_engine_test.sv
module padding_dma_engine_test;
  localparam logic [63:0] KEY = 64'h0F1E2D3C4B5A6978;
  localparam int DST = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, decrypt = 1'b0, littleEndian = 1'b0;
  logic [3:0]  waitStates = '0;
  logic [7:0]  hdrWords = '0;
  logic [15:0] payloadLen = '0;
  logic [31:0] srcAddr = 32'd0, dstAddr = 32'(DST);
  logic busReq, busWe;
  logic [31:0] busAddr, busWdata, busRdata;
  logic cipherInValid, cipherInReady, cipherOutValid, cipherOutReady;
  logic [63:0] cipherInData, cipherOutData;
  logic busy, doneIrq, padError;
  logic [16:0] outCount;

  always #4 clk = ~clk;

  padding_dma_engine uut (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt), .littleEndian(littleEndian),
    .waitStates(waitStates), .hdrWords(hdrWords), .payloadLen(payloadLen),
    .srcAddr(srcAddr), .dstAddr(dstAddr),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cipherInValid(cipherInValid), .cipherInReady(cipherInReady), .cipherInData(cipherInData),
    .cipherOutValid(cipherOutValid), .cipherOutReady(cipherOutReady), .cipherOutData(cipherOutData),
    .busy(busy), .doneIrq(doneIrq), .padError(padError), .outCount(outCount)
  );

  logic [7:0] memB [0:2047];
  logic [7:0] expB [0:1023];
  logic [7:0] plainB [0:63];
  int  total = 0, bad = 0;
  int  curWait = 0;
  bit  curLe = 0;
  bit  ended = 0;
  int  protoBad = 0, cipherBad = 0;

  // bus stub: true data only in the last cycle of an access
  int accCnt = 0;
  bit prevDone = 0;
  logic [31:0] lastA = '0;
  logic lastW = 0;
  always_comb begin
    if (busReq && accCnt == curWait) begin
      if (curLe) busRdata = {memB[{busAddr[10:2], 2'd3}], memB[{busAddr[10:2], 2'd2}],
                             memB[{busAddr[10:2], 2'd1}], memB[{busAddr[10:2], 2'd0}]};
      else       busRdata = {memB[{busAddr[10:2], 2'd0}], memB[{busAddr[10:2], 2'd1}],
                             memB[{busAddr[10:2], 2'd2}], memB[{busAddr[10:2], 2'd3}]};
    end else busRdata = 32'hDEADBEEF;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      accCnt <= 0; prevDone <= 0;
    end else if (busReq) begin
      if (accCnt != 0 && (busAddr != lastA || busWe != lastW)) protoBad <= protoBad + 1;
      if (accCnt == 0 && prevDone && busAddr == lastA && busWe == lastW) protoBad <= protoBad + 1;
      lastA <= busAddr; lastW <= busWe;
      prevDone <= (accCnt == curWait);
      if (accCnt == curWait) begin
        accCnt <= 0;
        if (busWe) begin
          for (int j = 0; j < 4; j++)
            memB[{busAddr[10:2], 2'(j)}] = curLe ? busWdata[8*j +: 8] : busWdata[31-8*j -: 8];
        end
      end else accCnt <= accCnt + 1;
    end else begin
      if (accCnt != 0) protoBad <= protoBad + 1;
      accCnt <= 0; prevDone <= 0;
    end
  end

  // cipher stub: XOR with KEY, one block in flight, random latency
  bit holding = 0, wasStall = 0;
  logic [63:0] held = '0, stallData = '0;
  int lat = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      holding <= 0; cipherInReady <= 0; cipherOutValid <= 0; cipherOutData <= '0; wasStall <= 0;
    end else begin
      if (wasStall && (!cipherInValid || cipherInData != stallData)) cipherBad <= cipherBad + 1;
      wasStall <= cipherInValid && !cipherInReady;
      stallData <= cipherInData;
      if (cipherInValid && cipherInReady) begin
        holding <= 1; held <= cipherInData ^ KEY; lat <= int'($urandom % 3); cipherInReady <= 0;
      end else cipherInReady <= !holding && ($urandom % 3 != 0);
      if (holding && !cipherOutValid) begin
        if (lat == 0) begin cipherOutValid <= 1; cipherOutData <= held; end
        else lat <= lat - 1;
      end
      if (cipherOutValid && cipherOutReady) begin cipherOutValid <= 0; holding <= 0; end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [7:0] kByte(input int i);
    return KEY[63-8*(i%8) -: 8];
  endfunction

  // fills plainB[0..pl+n-1] with random data plus n pad bytes; corrupt selects a bad trailer
  task automatic makeTrailer(input int pl, input int mode, output int plen);
    int n = 8 - pl % 8;
    for (int k = 0; k < 64; k++) plainB[k] = 8'($urandom);
    for (int k = 0; k < n; k++) plainB[pl + k] = 8'(n);
    plen = pl + n;
    if (mode == 1) plainB[plen-1] = 8'd0;
    if (mode == 2) plainB[plen-1] = 8'd9;
    if (mode == 3) begin
      for (int k = 0; k < 4; k++) plainB[plen-1-k] = 8'd4;
      plainB[plen-3] = 8'd5;
    end
  endtask

  task automatic runJob(input bit dec, input bit le, input int w, input int hdr, input int plen,
                        input bit poke);
    int hb = 4 * hdr;
    int written, expCnt, cyc, n, mism, firstIdx, pb0, cb0, pl;
    bit expErr, ok;
    string ptag;
    for (int i = 0; i < 256; i++) memB[i] = 8'($urandom);
    for (int i = 0; i < 256; i++) memB[DST + i] = 8'hEE;
    for (int i = 0; i < hb; i++) expB[i] = memB[i];
    if (!dec) begin
      for (int k = 0; k < 64; k++) plainB[k] = 8'($urandom);
      for (int k = 0; k < plen; k++) memB[hb + k] = plainB[k];
      n = 8 - plen % 8;
      pl = plen + n;
      for (int k = 0; k < pl; k++)
        expB[hb + k] = (k < plen ? plainB[k] : 8'(n)) ^ kByte(k);
      written = hb + pl; expCnt = written; expErr = 0;
      ptag = "R5";
    end else begin
      for (int k = 0; k < plen; k++) begin
        memB[hb + k] = plainB[k] ^ kByte(k);
        expB[hb + k] = plainB[k];
      end
      written = hb + plen;
      if (plen == 0) begin expCnt = hb; expErr = 0; end
      else begin
        n = int'(plainB[plen-1]);
        ok = (n >= 1 && n <= 8);
        if (ok) for (int k = 0; k < n; k++) if (plainB[plen-1-k] != 8'(n)) ok = 0;
        expErr = !ok;
        expCnt = ok ? written - n : written;
      end
      ptag = expErr ? "R7" : "R6";
    end
    pb0 = protoBad; cb0 = cipherBad;
    curWait = w; curLe = le;
    @(negedge clk);
    decrypt = dec; littleEndian = le; waitStates = 4'(w); hdrWords = 8'(hdr);
    payloadLen = 16'(plen); start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (5) @(negedge clk);
      chk(busy == 1, "R11 busy before extra start", longint'(busy), 1);
      decrypt = !dec; littleEndian = !le; waitStates = 4'(w + 1); payloadLen = 16'd3;
      hdrWords = 8'd0; start = 1;
      @(negedge clk);
      start = 0;
    end
    cyc = 0;
    while (!doneIrq && cyc < 6000) begin @(negedge clk); cyc++; end
    if (!doneIrq) begin
      chk(0, "R10 job timeout", 0, 1);
      finishRun();
    end
    chk(!busy, "R10 busy low at done", longint'(busy), 0);
    chk(outCount == 17'(expCnt), dec ? "R6 outCount" : "R10 outCount", longint'(outCount), expCnt);
    chk(padError == expErr, "R7 padError", longint'(padError), longint'(expErr));
    mism = 0; firstIdx = -1;
    for (int i = 0; i < hb; i++) if (memB[DST + i] != expB[i]) begin
      mism++; if (firstIdx < 0) firstIdx = i;
    end
    if (hdr > 0)
      chk(mism == 0, "R2 header copy", firstIdx < 0 ? 0 : longint'(memB[DST + firstIdx]),
          firstIdx < 0 ? 0 : longint'(expB[firstIdx]));
    mism = 0; firstIdx = -1;
    for (int i = hb; i < written; i++) if (memB[DST + i] != expB[i]) begin
      mism++; if (firstIdx < 0) firstIdx = i;
    end
    if (written > hb)
      chk(mism == 0, le ? {ptag, " R4 payload bytes"} : {ptag, " R3 payload bytes"},
          firstIdx < 0 ? 0 : longint'(memB[DST + firstIdx]),
          firstIdx < 0 ? 0 : longint'(expB[firstIdx]));
    chk(memB[DST + written] == 8'hEE, "R3 no write past end", longint'(memB[DST + written]), 8'hEE);
    chk(protoBad == pb0, "R8 access length", longint'(protoBad - pb0), 0);
    chk(cipherBad == cb0, "R9 cipher hold", longint'(cipherBad - cb0), 0);
    repeat (3) @(negedge clk);
    chk(doneIrq == 1, "R10 done sticky", longint'(doneIrq), 1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 190000) begin @(posedge clk); cyc++; end
    chk(0, "watchdog", cyc, 0);
    finishRun();
  end

  initial begin
    int plen, mode, pl;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !doneIrq && !padError, "R1 idle flags", {busy, doneIrq, padError}, 0);
    chk(!busReq && !cipherInValid, "R1 no activity", {busReq, cipherInValid}, 0);

    runJob(0, 0, 0, 0, 16, 0);   // R3 R5 exact multiple -> full pad block
    runJob(0, 1, 2, 2, 5, 0);    // R4 R2 R5 partial block
    runJob(0, 0, 3, 1, 0, 0);    // R5 empty payload
    runJob(0, 1, 1, 0, 13, 0);   // R4 R5
    makeTrailer(13, 0, plen); runJob(1, 0, 1, 1, plen, 0);  // R6 valid pad 3
    makeTrailer(8, 0, plen);  runJob(1, 1, 0, 0, plen, 0);  // R6 full pad block
    makeTrailer(5, 1, plen);  runJob(1, 0, 2, 0, plen, 0);  // R7 pad byte 0
    makeTrailer(10, 2, plen); runJob(1, 1, 0, 3, plen, 0);  // R7 pad byte 9
    makeTrailer(20, 3, plen); runJob(1, 0, 1, 0, plen, 0);  // R7 inconsistent
    runJob(1, 0, 0, 2, 0, 0);    // R6 empty decrypt payload
    runJob(0, 0, 3, 1, 40, 1);   // R11 start while busy

    for (int t = 0; t < 24; t++) begin
      mode = int'($urandom % 2);
      if (mode == 0) runJob(0, 1'($urandom), int'($urandom % 4), int'($urandom % 4),
                            int'($urandom % 41), 0);
      else begin
        pl = int'($urandom % 32);
        makeTrailer(pl, ($urandom % 3 == 0) ? int'(1 + $urandom % 3) : 0, plen);
        runJob(1, 1'($urandom), int'($urandom % 4), int'($urandom % 4), plen, 0);
      end
    end
    finishRun();
  end
endmodule